// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches forty-eight digital input lines, arranged as two groups of three 8-bit ports, and turns activity on them into one level-sensitive interrupt request. Any bit flip on a port that software has left unmasked sets a sticky request, so the host never has to poll the lines. Each group also offers an external interrupt: a rising edge on bit 3 of that group's third port (port C) latches a separate request, provided the group's strap enable is tied high. All pending requests are ORed onto a single active-high output that stays up until software writes the clear address.

The register bus is reduced to strobes that an address decoder outside the block produces. One strobe writes the six-bit mask register, with the data on a side bus. One strobe marks a write of any value to the clear address. A third strobe pulses on any read or write the card decodes. Interrupt generation is held off after reset until that access strobe has pulsed once. The mask register is active-low in sense: a 1 masks a port. It resets to zero, so every port is watched from the start.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset `irq_out` is low and the mask register holds zero, so a change on any port can raise the request once the block is armed.
- R2: Until `bus_access` has pulsed at least once after reset, no input change and no external edge raises `irq_out`, and no request is left pending from that period.
- R3: Once armed, a change of any bit on an unmasked port sets the change request, and `irq_out` stays high while the inputs stay still afterwards.
- R4: Mask bit i covers port i, and port i occupies `port_in[8*i+7:8*i]`. Ports 0, 1 and 2 are group 0 ports A, B and C, and ports 3, 4 and 5 are the same ports of group 1. A port whose mask bit is 1 raises no change request. A port whose bit is 0 still does.
- R5: A `clr_wr` pulse clears the change request and both external requests together, so `irq_out` falls when no new event arrives in that cycle.
- R6: When a new event and `clr_wr` fall in the same cycle, the request stays set.
- R7: With `strap_en[g]` high, a rising edge on port C bit 3 of group g (`port_in` bit 19 for group 0, bit 43 for group 1) latches an external request. The mask register has no effect on it. A falling edge, or any edge while the strap is low, latches nothing.
- R8: `irq_out` is the OR of the change request and the two external requests: any one of them alone drives it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_in | input | 48 | Six 8-bit input ports, port i at bits 8*i+7..8*i |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_data | input | 6 | Mask data, 1 masks the port of the same index |
| clr_wr | input | 1 | Write strobe for the clear address; data is ignored |
| bus_access | input | 1 | Pulses on any decoded read or write; arms the block |
| strap_en | input | 2 | Per-group strap enabling the external edge interrupt |
| irq_out | output | 1 | Active-high latched interrupt request |

## Verification
The two functions that can meet in one cycle are the setting of a request by a fresh input event and the clearing of all requests by a write to the clear address. The bench provokes the meeting by changing a port input and asserting the clear strobe exactly two clock edges later, which is when that change has passed through the synchronizer and is presented to the latch. The outcome counts as correct only if the request is still high afterwards and a later clear on its own brings it low.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;

    // Geometry of the watched inputs
    localparam int unsigned GROUPS      = 2;
    localparam int unsigned PORTS_PER_G = 3;
    localparam int unsigned PORT_W      = 8;
    localparam int unsigned NPORTS      = GROUPS * PORTS_PER_G;

    // Position of the external interrupt tap inside each group
    localparam int unsigned EXT_PORT    = 2;
    localparam int unsigned EXT_BIT     = 3;

    // Clock edges after reset before the sampled history is trustworthy
    localparam int unsigned FILL_EDGES  = 3;

endpackage

// File: rtl/cos_port_sampler.sv
module cos_port_sampler #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] hist;
    } smp_t;

    smp_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin;
        st_d.sync = st_q.meta;
        st_d.hist = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur = st_q.sync;
    assign prv = st_q.hist;

endmodule

// File: rtl/cos_ext_latch.sv
module cos_ext_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_cur,
    input  logic tap_prv,
    input  logic strap,
    input  logic armed,
    input  logic warm_ok,
    input  logic clr,
    output logic pend,
    output logic set_evt
);

    typedef struct packed {
        logic pend;
    } ext_t;

    ext_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        set_evt = armed && warm_ok && strap && tap_cur && !tap_prv;
        if (set_evt) begin
            st_d.pend = 1'b1;
        end else if (clr) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/cos_irq_core.sv
module cos_irq_core #(
    parameter int unsigned NP     = 6,
    parameter int unsigned W      = 8,
    parameter int unsigned FILL   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NP*W-1:0] cur_all,
    input  logic [NP*W-1:0] prv_all,
    input  logic            mask_wr,
    input  logic [NP-1:0]   mask_data,
    input  logic            clr_wr,
    input  logic            bus_access,
    output logic            armed,
    output logic            warm_ok,
    output logic            cos_pend,
    output logic            cos_set
);

    localparam int unsigned WW = $clog2(FILL + 1);

    typedef struct packed {
        logic [NP-1:0] mask;
        logic          armed;
        logic          cos;
        logic [WW-1:0] warm;
    } core_t;

    core_t st_d, st_q;
    logic [NP-1:0] port_chg;

    // One change flag per port: any bit differing from the previous sample
    for (genvar i = 0; i < NP; i++) begin : g_chg
        assign port_chg[i] = |(cur_all[i*W +: W] ^ prv_all[i*W +: W]);
    end

    assign warm_ok = (st_q.warm == WW'(FILL));

    always_comb begin
        st_d    = st_q;
        cos_set = st_q.armed && warm_ok && (|(port_chg & ~st_q.mask));

        if (!warm_ok) begin
            st_d.warm = st_q.warm + WW'(1);
        end
        if (mask_wr) begin
            st_d.mask = mask_data;
        end
        if (bus_access) begin
            st_d.armed = 1'b1;
        end
        if (cos_set) begin
            st_d.cos = 1'b1;
        end else if (clr_wr) begin
            st_d.cos = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed    = st_q.armed;
    assign cos_pend = st_q.cos;

endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
    import cos_irq_pkg::*;
#(
    parameter int unsigned N_GRP   = GROUPS,
    parameter int unsigned PPG     = PORTS_PER_G,
    parameter int unsigned PW      = PORT_W,
    parameter int unsigned TAP_P   = EXT_PORT,
    parameter int unsigned TAP_B   = EXT_BIT,
    parameter int unsigned N_FILL  = FILL_EDGES,
    localparam int unsigned NP     = N_GRP * PPG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP*PW-1:0] port_in,
    input  logic             mask_wr,
    input  logic [NP-1:0]    mask_data,
    input  logic             clr_wr,
    input  logic             bus_access,
    input  logic [N_GRP-1:0] strap_en,
    output logic             irq_out
);

    logic [NP*PW-1:0] cur_all;
    logic [NP*PW-1:0] prv_all;
    logic             armed;
    logic             warm_ok;
    logic             cos_pend;
    logic             cos_set;
    logic [N_GRP-1:0] ext_pend;
    logic [N_GRP-1:0] ext_set;
    logic             any_set;

    for (genvar i = 0; i < NP; i++) begin : g_port
        cos_port_sampler #(.W(PW)) u_smp (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (port_in[i*PW +: PW]),
            .cur  (cur_all[i*PW +: PW]),
            .prv  (prv_all[i*PW +: PW])
        );
    end

    cos_irq_core #(.NP(NP), .W(PW), .FILL(N_FILL)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_all   (cur_all),
        .prv_all   (prv_all),
        .mask_wr   (mask_wr),
        .mask_data (mask_data),
        .clr_wr    (clr_wr),
        .bus_access(bus_access),
        .armed     (armed),
        .warm_ok   (warm_ok),
        .cos_pend  (cos_pend),
        .cos_set   (cos_set)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_ext
        localparam int unsigned TAP_IDX = (g * PPG + TAP_P) * PW + TAP_B;
        cos_ext_latch u_ext (
            .clk    (clk),
            .rst_n  (rst_n),
            .tap_cur(cur_all[TAP_IDX]),
            .tap_prv(prv_all[TAP_IDX]),
            .strap  (strap_en[g]),
            .armed  (armed),
            .warm_ok(warm_ok),
            .clr    (clr_wr),
            .pend   (ext_pend[g]),
            .set_evt(ext_set[g])
        );
    end

    assign any_set = cos_set | (|ext_set);
    assign irq_out = cos_pend | (|ext_pend);

endmodule

// File: rtl/cos_irq_chk.sv
module cos_irq_chk (
    input logic clk,
    input logic rst_n,
    input logic clr_wr,
    input logic armed,
    input logic any_set,
    input logic irq_out
);

    // R2: nothing is requested before the first bus access
    p_disarmed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !irq_out);

    // R3: a pending request holds while no clear arrives
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !clr_wr) |=> irq_out);

    // R5: a clear with no fresh event drops the request
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !any_set) |=> !irq_out);

    // R6: a fresh event wins over a clear in the same cycle
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_set |=> irq_out);

    // R8: the output only rises through a recorded event
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && !any_set) |=> !irq_out);

endmodule

bind cos_irq_ctrl cos_irq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_wr (clr_wr),
    .armed  (armed),
    .any_set(any_set),
    .irq_out(irq_out)
);

// File: tb/tb_cos_irq_ctrl.sv
`timescale 1ns/1ps
module tb_cos_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [47:0] port_in;
    logic        mask_wr;
    logic [5:0]  mask_data;
    logic        clr_wr;
    logic        bus_access;
    logic [1:0]  strap_en;
    logic        irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bit    exp_q[$];
    string tag_q[$];
    event  chk_ev;

    always #5 clk = ~clk;

    cos_irq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_in   (port_in),
        .mask_wr   (mask_wr),
        .mask_data (mask_data),
        .clr_wr    (clr_wr),
        .bus_access(bus_access),
        .strap_en  (strap_en),
        .irq_out   (irq_out)
    );

    // Monitor: pops the expected value and compares it with the output
    initial begin
        forever begin
            bit    e;
            string t;
            @(chk_ev);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (irq_out !== e) begin
                n_fail++;
                $display("FAIL %s: irq_out=%b expected %b", t, irq_out, e);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_irq(input bit e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        #1;
        -> chk_ev;
        #1;
    endtask

    task automatic set_port(input int idx, input logic [7:0] v);
        port_in[idx*8 +: 8] = v;
    endtask

    task automatic pulse_clear();
        clr_wr = 1'b1;
        cycles(1);
        clr_wr = 1'b0;
    endtask

    task automatic write_mask(input logic [5:0] m);
        mask_data = m;
        mask_wr   = 1'b1;
        cycles(1);
        mask_wr   = 1'b0;
    endtask

    // Watchdog
    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        port_in    = '0;
        mask_wr    = 1'b0;
        mask_data  = '0;
        clr_wr     = 1'b0;
        bus_access = 1'b0;
        strap_en   = 2'b11;
        cycles(5);
        rst_n = 1'b1;
        cycles(1);
        expect_irq(1'b0, "R1 reset state");

        // R2: activity before arming is ignored
        set_port(0, 8'h01);
        cycles(6);
        expect_irq(1'b0, "R2 change before arming");
        port_in[19] = 1'b1;
        cycles(6);
        expect_irq(1'b0, "R2 external edge before arming");
        bus_access = 1'b1;
        cycles(1);
        bus_access = 1'b0;
        cycles(6);
        expect_irq(1'b0, "R2 nothing left pending after arming");

        // R1/R3: reset mask watches every port, request is sticky
        set_port(5, 8'h80);
        cycles(6);
        expect_irq(1'b1, "R1 R3 change on port 5 with reset mask");
        cycles(12);
        expect_irq(1'b1, "R3 request holds while inputs stay still");

        // R5: clear drops it
        pulse_clear();
        cycles(2);
        expect_irq(1'b0, "R5 clear drops change request");

        // R4: masking port 1 only
        write_mask(6'b000010);
        set_port(1, 8'h55);
        cycles(6);
        expect_irq(1'b0, "R4 masked port 1 ignored");
        set_port(3, 8'h10);
        cycles(6);
        expect_irq(1'b1, "R4 R8 unmasked port 3 still raises");
        pulse_clear();
        cycles(2);
        expect_irq(1'b0, "R5 clear after port 3");

        // R7: external edges, port C masked from change detection
        write_mask(6'b100100);
        strap_en = 2'b01;
        port_in[19] = 1'b0;
        cycles(6);
        expect_irq(1'b0, "R7 falling edge latches nothing");
        port_in[19] = 1'b1;
        cycles(6);
        expect_irq(1'b1, "R7 R8 rising edge group 0 with strap");
        pulse_clear();
        cycles(2);
        expect_irq(1'b0, "R5 clear drops external request");
        port_in[43] = 1'b1;
        cycles(6);
        expect_irq(1'b0, "R7 rising edge group 1 without strap");
        port_in[43] = 1'b0;
        cycles(6);
        strap_en = 2'b10;
        port_in[43] = 1'b1;
        cycles(6);
        expect_irq(1'b1, "R7 rising edge group 1 with strap");

        // R5/R8: both sources pending, one clear removes both
        set_port(0, 8'h03);
        cycles(6);
        expect_irq(1'b1, "R8 change and external both pending");
        pulse_clear();
        cycles(2);
        expect_irq(1'b0, "R5 single clear removes all sources");

        // R6: change reaches the latch in the same cycle as a clear
        set_port(0, 8'h07);
        cycles(6);
        expect_irq(1'b1, "R6 setup request pending");
        set_port(0, 8'h0F);
        cycles(2);
        pulse_clear();
        cycles(1);
        expect_irq(1'b1, "R6 set wins over same-cycle clear");
        pulse_clear();
        cycles(2);
        expect_irq(1'b0, "R6 later clear alone drops it");
        set_port(0, 8'h1F);
        cycles(2);
        pulse_clear();
        cycles(1);
        expect_irq(1'b1, "R6 set wins from idle latch");
        pulse_clear();
        cycles(2);
        expect_irq(1'b0, "R5 clear after R6 case");

        // R4/R7: full mask blocks change, external still works
        write_mask(6'b111111);
        port_in = ~port_in;
        cycles(6);
        port_in[43] = 1'b0;
        cycles(6);
        expect_irq(1'b0, "R4 full mask blocks every port");
        port_in[43] = 1'b1;
        cycles(6);
        expect_irq(1'b1, "R7 external edge ignores mask register");
        pulse_clear();
        cycles(2);
        expect_irq(1'b0, "R5 final clear");

        cycles(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule